// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block sits ahead of the current-steering DAC or fractional divider of a spread-spectrum clock PLL. It produces a signed frequency-offset code whose unit is one hundredth of a percent of the nominal output frequency. When modulation is on, the code traces a symmetric triangle with one full sweep per modulation period, which is 80 µs at the default rate of 12.5 kHz. Each step moves the code by exactly one unit, so the sequence of codes is glitch-free. A 2-bit select chooses the depth of the sweep. It also chooses whether the sweep is centred on the nominal frequency or kept entirely below it.

The enable and select pins are asynchronous to the block. Every settings change restarts the profile from nominal and opens a lock window. A `settled` flag marks the point after which downstream logic may trust the modulated clock. The system clock, the modulation rate and the length of the lock window are all parameters. The step interval is derived from them.

Top module: `ssc_profile_gen`

## Requirements
- R1: Select 00 gives a centred sweep between +150 and −150. Select 01 gives a centred sweep between +50 and −50. In both cases the code first reaches the positive peak after a quarter of a period.
- R2: Select 10 gives a downward sweep between 0 and −100. Select 11 gives a downward sweep between 0 and −300. The code never goes above 0 in either of these settings, and it reaches its lowest value after half a period.
- R3: While the synchronized enable is low, the offset is exactly 0 on every cycle.
- R4: The code changes by exactly one unit per step, with no larger jump between turning points. Steps per period are 600 for selects 00 and 11, and 200 for selects 01 and 10.
- R5: The step interval is floor((CLK_HZ/MOD_HZ)/steps) clocks. One period therefore lasts steps × interval clocks: 9600 clocks for selects 00 and 11, and 10000 clocks for selects 01 and 10 at the defaults. After one period the code is back at 0.
- R6: A change of enable or select restarts the profile at 0. The first step is +1 for centred settings and −1 for downward settings, and it comes one step interval after the restart.
- R7: Enable and select pass through two synchronizer flops. A change on the pins takes effect at the third rising clock edge after it, and the outputs are unchanged at the second edge.
- R8: `settled_o` falls at the restart edge. It rises LOCK_CYCLES+1 edges later if no further change arrives.
- R9: A change that arrives during the lock window reloads the window. `settled_o` then rises LOCK_CYCLES+1 edges after the last restart.
- R10: During reset the offset is 0 and `settled_o` is low. After reset is released with enable low and select 00, `settled_o` rises at the (LOCK_CYCLES+1)th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Modulation enable (asynchronous) |
| rate_sel_i | input | 2 | Depth and centred/downward choice (asynchronous) |
| offset_o | output | 10 | Signed offset, in units of 0.01 % of nominal |
| settled_o | output | 1 | Lock window has elapsed since the last restart |

## Verification
Pin changes are driven on a falling edge, and each output is sampled on a later falling edge after a known number of rising edges has been counted. A restart appears at edge 3, and the bench also confirms that nothing has moved at edge 2. The first step appears at edge 3 plus one interval. `settled_o` is still low at edge LOCK_CYCLES+3 and high at edge LOCK_CYCLES+4, both counted from the last change. Peak values, the step count and the return to 0 are all checked against edge numbers the bench computes from the period formula, so a slip of a single cycle in any stage shows up as a mismatch.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned OFF_W = 10;
  typedef logic signed [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    SEL_C150 = 2'b00,
    SEL_C50  = 2'b01,
    SEL_D100 = 2'b10,
    SEL_D300 = 2'b11
  } rate_sel_e;

  typedef struct packed {
    logic      en;
    rate_sel_e sel;
  } cfg_t;

  function automatic logic is_down(input logic [1:0] s);
    return s[1];
  endfunction

  // peak-to-peak excursion in code units
  function automatic int excursion(input logic [1:0] s);
    case (s)
      2'b00:   return 300;
      2'b01:   return 100;
      2'b10:   return 100;
      default: return 300;
    endcase
  endfunction

  function automatic int steps_per_period(input logic [1:0] s);
    return 2 * excursion(s);
  endfunction

  function automatic off_t hi_code(input logic [1:0] s);
    return is_down(s) ? off_t'(0) : off_t'(excursion(s) / 2);
  endfunction

  function automatic off_t lo_code(input logic [1:0] s);
    return is_down(s) ? off_t'(-excursion(s)) : off_t'(-(excursion(s) / 2));
  endfunction
endpackage

// File: rtl/ssc_cfg_sync.sv
module ssc_cfg_sync
  import ssc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output cfg_t       cfg_o,
  output logic       chg_o
);
  cfg_t meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= '{en: en_i, sel: rate_sel_e'(sel_i)};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cfg_o = sync_q;
  assign chg_o = (sync_q != prev_q);

  // a change is reported for one cycle only
  p_chg_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> !chg_o);
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
  import ssc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned MOD_HZ = 12_500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic restart_i,
  output off_t off_o
);
  localparam int unsigned PERIOD_CLKS = CLK_HZ / MOD_HZ;
  localparam int unsigned DIV_W       = $clog2(PERIOD_CLKS + 1);

  logic [DIV_W-1:0] term_tbl [4];

  for (genvar g = 0; g < 4; g++) begin : g_term
    localparam int unsigned STEP_DIV = PERIOD_CLKS / steps_per_period(2'(g));
    assign term_tbl[g] = DIV_W'(STEP_DIV - 1);
  end

  off_t             off_q, off_nxt, hi, lo;
  logic             up_q;
  logic [DIV_W-1:0] cnt_q;

  assign hi      = hi_code(cfg_i.sel);
  assign lo      = lo_code(cfg_i.sel);
  assign off_nxt = up_q ? off_q + off_t'(1) : off_q - off_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      up_q  <= 1'b1;
      cnt_q <= '0;
    end else if (restart_i) begin
      off_q <= '0;
      up_q  <= !is_down(cfg_i.sel);
      cnt_q <= '0;
    end else if (!cfg_i.en) begin
      off_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q == term_tbl[cfg_i.sel]) begin
      cnt_q <= '0;
      off_q <= off_nxt;
      if (up_q && off_nxt == hi)       up_q <= 1'b0;
      else if (!up_q && off_nxt == lo) up_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign off_o = off_q;

  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && cfg_i.en) |=> ((off_q == $past(off_q)) ||
                                  (off_q == $past(off_q) + off_t'(1)) ||
                                  (off_q == $past(off_q) - off_t'(1))));

  p_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (off_q <= hi && off_q >= lo));

  p_down_nonpos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && is_down(cfg_i.sel)) |-> off_q <= off_t'(0));

  p_dis_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> off_q == off_t'(0));

  p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> off_q == off_t'(0));
endmodule

// File: rtl/ssc_lock_timer.sv
module ssc_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 625_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic settled_o
);
  localparam int unsigned LK_W = $clog2(LOCK_CYCLES + 1);

  logic [LK_W-1:0] cnt_q;
  logic            settled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= LK_W'(LOCK_CYCLES);
      settled_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q     <= LK_W'(LOCK_CYCLES);
      settled_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LK_W'(1);
    end else begin
      settled_q <= 1'b1;
    end
  end

  assign settled_o = settled_q;

  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !settled_q);

  p_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && cnt_q == '0) |=> settled_q);

  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == LK_W'(LOCK_CYCLES));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_q && !restart_i) |=> settled_q);
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned MOD_HZ      = 12_500,
  parameter int unsigned LOCK_CYCLES = 625_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mod_en_i,
  input  logic [1:0]              rate_sel_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    settled_o
);
  cfg_t cfg;
  logic chg;
  off_t off;

  ssc_cfg_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mod_en_i),
    .sel_i  (rate_sel_i),
    .cfg_o  (cfg),
    .chg_o  (chg)
  );

  ssc_tri_gen #(
    .CLK_HZ (CLK_HZ),
    .MOD_HZ (MOD_HZ)
  ) u_tri (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .restart_i (chg),
    .off_o     (off)
  );

  ssc_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (chg),
    .settled_o (settled_o)
  );

  assign offset_o = off;
endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;
  localparam int LOCK = 40;
  localparam int PER  = 10000; // CLK_HZ / MOD_HZ

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        sel = 2'b00;
  logic signed [9:0] offset;
  logic              settled;
  int                n_chk = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  ssc_profile_gen #(
    .CLK_HZ      (125_000_000),
    .MOD_HZ      (12_500),
    .LOCK_CYCLES (LOCK)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mod_en_i   (en),
    .rate_sel_i (sel),
    .offset_o   (offset),
    .settled_o  (settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; sel = 2'b00;
    edges(3);
    chk(offset == 0, "R10 offset in reset", int'(offset), 0);
    chk(settled == 0, "R10 settled in reset", int'(settled), 0);
    rst_n = 1'b1;
    edges(LOCK);
    chk(settled == 0, "R10 settled before window end", int'(settled), 0);
    edges(1);
    chk(settled == 1, "R10 settled after window", int'(settled), 1);
    chk(offset == 0, "R3 offset while disabled", int'(offset), 0);
  endtask

  task automatic t_mode(input logic [1:0] s, input int exc, input bit down, input string req);
    int steps = 2 * exc;
    int dv    = PER / steps;
    int per   = steps * dv;
    int hi    = down ? 0 : exc / 2;
    int lo    = down ? -exc : -(exc / 2);
    int pk_n  = down ? 3 + exc * dv : 3 + (exc / 2) * dv;
    int prev = 0, mx = 0, mn = 0, nchg = 0, bad = 0, first = -1, fdir = 0, pk = 0;
    @(negedge clk);
    en = 1'b1; sel = s;
    for (int n = 1; n <= 3 + per; n++) begin
      int v, d;
      edges(1);
      v = int'(offset);
      if (n == 3) begin
        chk(v == 0, "R6 restart at nominal", v, 0);
        chk(settled == 0, "R8 settled falls on change", int'(settled), 0);
        prev = v;
      end else if (n > 3) begin
        d = v - prev;
        if (d > 1 || d < -1) bad++;
        if (d != 0) begin
          nchg++;
          if (first < 0) begin first = n; fdir = d; end
        end
        if (v > mx) mx = v;
        if (v < mn) mn = v;
        if (n == pk_n) pk = v;
        prev = v;
      end
    end
    chk(first == 3 + dv, "R5 first step edge", first, 3 + dv);
    chk(fdir == (down ? -1 : 1), "R6 first step direction", fdir, down ? -1 : 1);
    chk(bad == 0, "R4 unit steps", bad, 0);
    chk(nchg == steps, "R4 steps per period", nchg, steps);
    chk(prev == 0, "R5 back to nominal after period", prev, 0);
    chk(mx == hi, {req, " upper peak"}, mx, hi);
    chk(mn == lo, {req, " lower peak"}, mn, lo);
    chk(pk == (down ? lo : hi), {req, " peak timing"}, pk, down ? lo : hi);
    chk(settled == 1, "R8 settled after window", int'(settled), 1);
  endtask

  task automatic t_settle();
    @(negedge clk);
    sel = 2'b10;
    edges(2);
    chk(settled == 1, "R7 no effect at edge 2", int'(settled), 1);
    edges(1);
    chk(settled == 0, "R8 drop at edge 3", int'(settled), 0);
    edges(LOCK);
    chk(settled == 0, "R8 still low at LOCK+3", int'(settled), 0);
    edges(1);
    chk(settled == 1, "R8 high at LOCK+4", int'(settled), 1);
  endtask

  task automatic t_reload();
    @(negedge clk);
    sel = 2'b01;
    edges(13);
    chk(settled == 0, "R9 low inside window", int'(settled), 0);
    sel = 2'b00;
    edges(LOCK + 3);
    chk(settled == 0, "R9 window reloaded", int'(settled), 0);
    edges(1);
    chk(settled == 1, "R9 high after reloaded window", int'(settled), 1);
  endtask

  task automatic t_disable();
    int bad = 0;
    @(negedge clk);
    sel = 2'b01; en = 1'b1;
    edges(3 + 3 * 50);
    chk(offset == 3, "R6 running before disable", int'(offset), 3);
    en = 1'b0;
    edges(2);
    chk(offset == 3, "R7 unchanged at edge 2", int'(offset), 3);
    edges(1);
    chk(offset == 0, "R3 zero at edge 3", int'(offset), 0);
    for (int n = 0; n < 3000; n++) begin
      edges(1);
      if (offset != 0) bad++;
    end
    chk(bad == 0, "R3 held at zero while disabled", bad, 0);
    chk(settled == 1, "R8 settled while disabled", int'(settled), 1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_mode(2'b00, 300, 1'b0, "R1");
    t_mode(2'b01, 100, 1'b0, "R1");
    t_mode(2'b10, 100, 1'b1, "R2");
    t_mode(2'b11, 300, 1'b1, "R2");
    t_settle();
    t_reload();
    t_disable();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule